// File: doc/BRIEF.md
# Temperature Limit Alarm Controller

This block watches a stream of temperature conversion results from two sensing zones: a local zone (zone 0) and a remote-diode zone (zone 1). Each zone has its own programmable high and low limit. Each conversion result is compared against the limits of the zone it belongs to. Any violation, and any open-circuit fault on the remote diode, sets a sticky bit in an 8-bit status value.

The status value is presented in parallel for the bus logic to return on a status read. A status-read strobe clears each bit whose cause has gone away. While any status bit is set, the block asks for an open-drain alert line to be pulled low. It lets the line go only after two things have happened:

- every status bit has been cleared, and
- the bus responder has finished an alert-response transaction.

A mask bit in the configuration register keeps the line from being driven. The status bits go on updating while the line is masked.

Top module: `temp_alarm_ctrl`

## Requirements
- R1: A conversion of zone z sets that zone's high status bit when the signed 8-bit result is strictly greater than the zone's high limit. The bit is set at the clock edge that samples `conv_valid`.
- R2: A conversion of zone z sets that zone's low status bit when the signed result is less than or equal to the zone's low limit. The bit is set at the same edge.
- R3: Each zone has its own limits. A write with `lim_wr_en` targets zone `lim_wr_zone`; `lim_wr_hi`=1 selects the high limit and 0 selects the low limit. Status bit positions are: zone 0 high = bit 6, zone 0 low = bit 5, zone 1 high = bit 4, zone 1 low = bit 3. Bits 7, 1 and 0 read 0.
- R4: While `diode_open` is high, status bit 2 is set on every clock edge.
- R5: A set status bit stays set until a `status_rd` strobe. At that strobe it clears only if its condition is absent. For a temperature bit, the condition is the comparison result of the most recent earlier conversion of that zone. For bit 2, the condition is the `diode_open` level.
- R6: When a new alarm event and `status_rd` fall in the same cycle, the event wins and the bit stays set.
- R7: `alert_pull_low` becomes 1 one cycle after any status bit is set. It stays 1 until an `ara_done` pulse arrives while all status bits are 0. An `ara_done` pulse while any status bit is set has no effect.
- R8: Configuration bit 7 (written through `cfg_wr_en`/`cfg_wr_data`) holds `alert_pull_low` at 0 while it is 1. The status bits keep updating. The pending alert is kept and drives the line again once the mask is removed.
- R9: After reset the status is 0, `alert_pull_low` is 0 and the mask is off. Every high limit is +127 and every low limit is -128, so a result of -128 raises a low alarm and no result raises a high alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_valid | input | 1 | One-cycle strobe: a conversion result is present |
| conv_zone | input | 1 | Zone of the result (0 local, 1 remote) |
| conv_temp | input | 8 | Signed two's-complement temperature |
| diode_open | input | 1 | Remote diode open-circuit fault level |
| lim_wr_en | input | 1 | Limit write strobe |
| lim_wr_zone | input | 1 | Zone of the limit write |
| lim_wr_hi | input | 1 | 1 writes the high limit, 0 writes the low limit |
| lim_wr_data | input | 8 | Signed limit value |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 8 | Configuration data; bit 7 masks the alert line |
| status_rd | input | 1 | One-cycle strobe: the status value is being read |
| ara_done | input | 1 | One-cycle pulse: an alert-response transaction completed |
| status_q | output | 8 | Sticky alarm status |
| alert_pull_low | output | 1 | Open-drain enable: 1 sinks the alert line, 0 releases it |

## Verification
The assertions rely on the strobes `conv_valid`, `status_rd` and `ara_done` being synchronous to `clk`. They also rely on `conv_zone` being 0 or 1 whenever `conv_valid` is high. Limit and configuration writes are assumed to change state only at the edge that samples their strobe. The bench drives every input on the falling edge and holds each strobe for exactly one cycle. It always tags conversions with a valid zone. It reprograms limits only while no conversion is in flight, so each comparison sees settled limits.

// File: rtl/temp_alarm_pkg.sv
package temp_alarm_pkg;

   localparam int DIODE_BIT = 2;

   // Zone 0 occupies the highest pair of status bits, and later zones go below it.
   function automatic int zone_lo_bit(input int zone, input int num_zones);
      return DIODE_BIT + 1 + 2 * (num_zones - 1 - zone);
   endfunction

   function automatic int zone_hi_bit(input int zone, input int num_zones);
      return zone_lo_bit(zone, num_zones) + 1;
   endfunction

   function automatic int min_status_width(input int num_zones);
      return DIODE_BIT + 1 + 2 * num_zones;
   endfunction

endpackage

// File: rtl/tac_zone_unit.sv
module tac_zone_unit #(
   parameter int TEMP_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_hi,
   input  logic                     wr_lo,
   input  logic signed [TEMP_W-1:0] wr_data,
   input  logic                     conv_hit,
   input  logic signed [TEMP_W-1:0] conv_temp,
   output logic                     hi_evt,
   output logic                     lo_evt,
   output logic                     hi_cond,
   output logic                     lo_cond
);
   localparam logic signed [TEMP_W-1:0] HI_RST = {1'b0, {(TEMP_W-1){1'b1}}};
   localparam logic signed [TEMP_W-1:0] LO_RST = {1'b1, {(TEMP_W-1){1'b0}}};

   logic signed [TEMP_W-1:0] hi_lim_q, lo_lim_q;
   logic                     above, at_or_below;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_lim_q <= HI_RST;
         lo_lim_q <= LO_RST;
      end else begin
         if (wr_hi) hi_lim_q <= wr_data;
         if (wr_lo) lo_lim_q <= wr_data;
      end
   end

   assign above       = conv_temp >  hi_lim_q;
   assign at_or_below = conv_temp <= lo_lim_q;
   assign hi_evt      = conv_hit & above;
   assign lo_evt      = conv_hit & at_or_below;

   // Condition flags hold the verdict of the latest conversion for this zone.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cond <= 1'b0;
         lo_cond <= 1'b0;
      end else if (conv_hit) begin
         hi_cond <= above;
         lo_cond <= at_or_below;
      end
   end

   assert_cond_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_hit |=> $stable({hi_cond, lo_cond}));

   assert_limit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_hi || wr_lo) |=> $stable({hi_lim_q, lo_lim_q}));

endmodule

// File: rtl/tac_status.sv
module tac_status #(
   parameter int STATUS_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [STATUS_W-1:0] set_vec,
   input  logic [STATUS_W-1:0] cond_vec,
   input  logic                rd,
   output logic [STATUS_W-1:0] status_q
);
   logic [STATUS_W-1:0] keep_mask;

   assign keep_mask = rd ? cond_vec : {STATUS_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= set_vec | (status_q & keep_mask);
   end

   assert_sticky_no_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> (($past(status_q) & ~status_q) == '0));

   assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

   assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd |=> ((status_q & ~$past(set_vec) & ~$past(cond_vec)) == '0));

endmodule

// File: rtl/tac_alert.sv
module tac_alert (
   input  logic clk,
   input  logic rst_n,
   input  logic any_status,
   input  logic ara_done,
   input  logic mask,
   output logic pull_low
);
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pend_q <= 1'b0;
      else if (any_status) pend_q <= 1'b1;
      else if (ara_done)   pend_q <= 1'b0;
   end

   assign pull_low = pend_q & ~mask;

   assert_alert_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      any_status |=> pend_q);

   assert_alert_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !ara_done) |=> pend_q);

   assert_alert_rises_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past(any_status));

endmodule

// File: rtl/temp_alarm_ctrl.sv
module temp_alarm_ctrl #(
   parameter int NUM_ZONES = 2,
   parameter int TEMP_W    = 8,
   parameter int STATUS_W  = 8,
   parameter int CFG_W     = 8,
   parameter int MASK_BIT  = 7,
   localparam int ZONE_W   = (NUM_ZONES > 1) ? $clog2(NUM_ZONES) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     conv_valid,
   input  logic [ZONE_W-1:0]        conv_zone,
   input  logic signed [TEMP_W-1:0] conv_temp,
   input  logic                     diode_open,
   input  logic                     lim_wr_en,
   input  logic [ZONE_W-1:0]        lim_wr_zone,
   input  logic                     lim_wr_hi,
   input  logic signed [TEMP_W-1:0] lim_wr_data,
   input  logic                     cfg_wr_en,
   input  logic [CFG_W-1:0]         cfg_wr_data,
   input  logic                     status_rd,
   input  logic                     ara_done,
   output logic [STATUS_W-1:0]      status_q,
   output logic                     alert_pull_low
);
   import temp_alarm_pkg::*;

   if (NUM_ZONES < 1) begin : g_bad_zones
      $error("temp_alarm_ctrl: NUM_ZONES must be at least 1");
   end
   if (STATUS_W < min_status_width(NUM_ZONES)) begin : g_bad_status
      $error("temp_alarm_ctrl: STATUS_W too small for NUM_ZONES");
   end
   if (MASK_BIT >= CFG_W) begin : g_bad_mask
      $error("temp_alarm_ctrl: MASK_BIT outside configuration word");
   end
   if (TEMP_W < 2) begin : g_bad_temp
      $error("temp_alarm_ctrl: TEMP_W must be at least 2");
   end

   logic [STATUS_W-1:0] set_vec, cond_vec;
   logic [NUM_ZONES-1:0] hi_evt, lo_evt, hi_cond, lo_cond;
   logic mask_q;
   logic unused_cfg_bits;

   assign unused_cfg_bits = ^cfg_wr_data;

   for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
      logic hit, wr_sel;
      assign hit    = conv_valid  && (conv_zone   == ZONE_W'(z));
      assign wr_sel = lim_wr_en   && (lim_wr_zone == ZONE_W'(z));

      tac_zone_unit #(.TEMP_W(TEMP_W)) u_zone (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_hi     (wr_sel &  lim_wr_hi),
         .wr_lo     (wr_sel & ~lim_wr_hi),
         .wr_data   (lim_wr_data),
         .conv_hit  (hit),
         .conv_temp (conv_temp),
         .hi_evt    (hi_evt[z]),
         .lo_evt    (lo_evt[z]),
         .hi_cond   (hi_cond[z]),
         .lo_cond   (lo_cond[z])
      );
   end

   always_comb begin
      set_vec  = '0;
      cond_vec = '0;
      for (int z = 0; z < NUM_ZONES; z++) begin
         set_vec [zone_hi_bit(z, NUM_ZONES)] = hi_evt[z];
         set_vec [zone_lo_bit(z, NUM_ZONES)] = lo_evt[z];
         cond_vec[zone_hi_bit(z, NUM_ZONES)] = hi_cond[z];
         cond_vec[zone_lo_bit(z, NUM_ZONES)] = lo_cond[z];
      end
      set_vec [DIODE_BIT] = diode_open;
      cond_vec[DIODE_BIT] = diode_open;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mask_q <= 1'b0;
      else if (cfg_wr_en) mask_q <= cfg_wr_data[MASK_BIT];
   end

   tac_status #(.STATUS_W(STATUS_W)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_vec  (set_vec),
      .cond_vec (cond_vec),
      .rd       (status_rd),
      .status_q (status_q)
   );

   tac_alert u_alert (
      .clk        (clk),
      .rst_n      (rst_n),
      .any_status (|status_q),
      .ara_done   (ara_done),
      .mask       (mask_q),
      .pull_low   (alert_pull_low)
   );

   assert_diode_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      diode_open |=> status_q[DIODE_BIT]);

   assert_unused_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q & ~(set_vec | cond_vec | {STATUS_W{1'b1}} << DIODE_BIT)) == '0);

   assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_en && cfg_wr_data[MASK_BIT]) |=> !alert_pull_low);

endmodule

// File: tb/temp_alarm_ctrl_test.sv
`timescale 1ns/1ps
module temp_alarm_ctrl_test;

   logic clk = 1'b0;
   logic rst_n;
   logic conv_valid, conv_zone, diode_open;
   logic signed [7:0] conv_temp, lim_wr_data;
   logic lim_wr_en, lim_wr_zone, lim_wr_hi, cfg_wr_en;
   logic [7:0] cfg_wr_data;
   logic status_rd, ara_done;
   logic [7:0] status_q;
   logic alert_pull_low;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   temp_alarm_ctrl uut (
      .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_zone(conv_zone),
      .conv_temp(conv_temp), .diode_open(diode_open), .lim_wr_en(lim_wr_en),
      .lim_wr_zone(lim_wr_zone), .lim_wr_hi(lim_wr_hi), .lim_wr_data(lim_wr_data),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .status_rd(status_rd),
      .ara_done(ara_done), .status_q(status_q), .alert_pull_low(alert_pull_low)
   );

   // Vector fields: {zone, temp[7:0], expect_high, expect_low}
   localparam logic [10:0] VEC [12] = '{
      {1'b0, 8'd50,  1'b0, 1'b0},
      {1'b0, 8'd51,  1'b1, 1'b0},
      {1'b0, 8'd10,  1'b0, 1'b1},
      {1'b0, 8'd11,  1'b0, 1'b0},
      {1'b0, 8'h80,  1'b0, 1'b1},
      {1'b0, 8'd127, 1'b1, 1'b0},
      {1'b1, 8'd80,  1'b0, 1'b0},
      {1'b1, 8'd81,  1'b1, 1'b0},
      {1'b1, 8'hEC,  1'b0, 1'b1},
      {1'b1, 8'hED,  1'b0, 1'b0},
      {1'b1, 8'd51,  1'b0, 1'b0},
      {1'b1, 8'hEB,  1'b0, 1'b1}
   };

   function automatic int hi_pos(input logic z); return z ? 4 : 6; endfunction
   function automatic int lo_pos(input logic z); return z ? 3 : 5; endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic idle();
      conv_valid = 0; conv_zone = 0; conv_temp = 0; diode_open = 0;
      lim_wr_en = 0; lim_wr_zone = 0; lim_wr_hi = 0; lim_wr_data = 0;
      cfg_wr_en = 0; cfg_wr_data = 0; status_rd = 0; ara_done = 0;
   endtask

   task automatic do_reset();
      @(negedge clk); idle(); rst_n = 0;
      @(negedge clk); @(negedge clk); rst_n = 1;
      @(negedge clk);
   endtask

   task automatic conv(input logic z, input logic signed [7:0] t);
      @(negedge clk); conv_valid = 1; conv_zone = z; conv_temp = t;
      @(negedge clk); conv_valid = 0;
   endtask

   task automatic rd();
      @(negedge clk); status_rd = 1;
      @(negedge clk); status_rd = 0;
   endtask

   task automatic ara();
      @(negedge clk); ara_done = 1;
      @(negedge clk); ara_done = 0;
   endtask

   task automatic wr_lim(input logic z, input logic hi, input logic signed [7:0] d);
      @(negedge clk); lim_wr_en = 1; lim_wr_zone = z; lim_wr_hi = hi; lim_wr_data = d;
      @(negedge clk); lim_wr_en = 0;
   endtask

   task automatic wr_cfg(input logic [7:0] d);
      @(negedge clk); cfg_wr_en = 1; cfg_wr_data = d;
      @(negedge clk); cfg_wr_en = 0;
   endtask

   task automatic clear_all();
      conv(0, 8'sd30); conv(1, 8'sd30); rd(); ara();
   endtask

   initial begin
      #(200000 * 5.0);
      if (!done) begin
         failures++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      idle(); rst_n = 0;
      do_reset();

      // R9: reset state
      chk("R9", "status after reset", status_q, 8'h00);
      chk("R9", "alert after reset", alert_pull_low, 1'b0);
      conv(0, 8'sd127);
      chk("R9", "reset high limit +127 no alarm", status_q, 8'h00);
      conv(1, -8'sd128);
      chk("R9", "reset low limit -128 alarms", status_q, 8'h08);
      clear_all();
      chk("R9", "cleared", status_q, 8'h00);

      // Program limits: zone0 hi 50 lo 10, zone1 hi 80 lo -20
      wr_lim(0, 1, 8'sd50); wr_lim(0, 0, 8'sd10);
      wr_lim(1, 1, 8'sd80); wr_lim(1, 0, -8'sd20);

      // R1 R2 R3: table walk
      for (int i = 0; i < 12; i++) begin
         logic z; logic [7:0] t; logic eh, el; logic [7:0] exp;
         {z, t, eh, el} = VEC[i];
         conv(z, t);
         exp = '0;
         exp[hi_pos(z)] = eh;
         exp[lo_pos(z)] = el;
         chk(eh ? "R1" : "R2", $sformatf("vector %0d R3 zone/bit map", i), status_q, exp);
         clear_all();
         chk("R5", $sformatf("vector %0d cleared", i), status_q, 8'h00);
      end

      // R5: sticky without read, held at read while condition present
      conv(0, 8'sd60);
      conv(0, 8'sd60);
      rd();
      chk("R5", "read with condition present keeps bit", status_q, 8'h40);
      conv(0, 8'sd20);
      chk("R5", "condition gone, no read keeps bit", status_q, 8'h40);
      rd();
      chk("R5", "read after condition gone clears", status_q, 8'h00);

      // R6: event and read in same cycle
      conv(1, 8'sd90);
      conv(1, 8'sd0);
      @(negedge clk); conv_valid = 1; conv_zone = 1; conv_temp = 8'sd90; status_rd = 1;
      @(negedge clk); conv_valid = 0; status_rd = 0;
      chk("R6", "event wins over read", status_q, 8'h10);
      conv(1, 8'sd0); rd(); ara();
      chk("R6", "later read clears", status_q, 8'h00);

      // R4: diode fault
      @(negedge clk); diode_open = 1;
      @(negedge clk);
      chk("R4", "diode bit set", status_q, 8'h04);
      rd();
      chk("R4", "read with diode open keeps bit", status_q, 8'h04);
      @(negedge clk); diode_open = 0;
      rd();
      chk("R4", "read after diode restored clears", status_q, 8'h00);
      ara();

      // R7: alert timing and release
      chk("R7", "alert idle", alert_pull_low, 1'b0);
      @(negedge clk); conv_valid = 1; conv_zone = 0; conv_temp = 8'sd70;
      @(negedge clk); conv_valid = 0;
      chk("R7", "alert not yet on status edge", alert_pull_low, 1'b0);
      @(negedge clk);
      chk("R7", "alert one cycle after status", alert_pull_low, 1'b1);
      ara();
      chk("R7", "ara while status set ignored", alert_pull_low, 1'b1);
      conv(0, 8'sd20); rd();
      chk("R7", "status clear", status_q, 8'h00);
      @(negedge clk);
      chk("R7", "alert held after status clear", alert_pull_low, 1'b1);
      ara();
      chk("R7", "alert released by ara", alert_pull_low, 1'b0);

      // R8: mask
      wr_cfg(8'h80);
      conv(1, -8'sd30);
      @(negedge clk);
      chk("R8", "status updates while masked", status_q, 8'h08);
      chk("R8", "alert masked", alert_pull_low, 1'b0);
      wr_cfg(8'h00);
      chk("R8", "pending alert after unmask", alert_pull_low, 1'b1);
      clear_all();
      chk("R8", "alert released", alert_pull_low, 1'b0);

      // R3: limit written for one zone leaves the other alone
      wr_lim(1, 1, 8'sd20);
      conv(0, 8'sd40);
      chk("R3", "zone0 unaffected by zone1 write", status_q, 8'h00);
      conv(1, 8'sd21);
      chk("R3", "zone1 new high limit", status_q, 8'h10);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule